// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a small single-port synchronous memory whose control, address and byte-lane strobes are registered on the rising clock edge. A read returns its word combinationally from the registered address, so the data is valid in the cycle right after the command edge. A write hands over its data one enabled edge after the command. That offset lets a read follow a write, or a write follow a read, on every clock with no idle cycle between them.

Incoming write data lands in a pending-write register. The array is updated from that register when the next write's data arrives. A read that hits the pending address takes the pending lanes in place of the stale array lanes. The word is built from lanes of 9 bits each, and each lane has its own strobe. The block has an active-low clock enable that freezes it, three chip selects, and an asynchronous output enable.

The data bus leaves the block as a drive value plus a drive-enable, ready for a bidirectional pad. The memory has fixed timing and never stalls, so no valid/ready handshake is used. The clock enable is the only way to hold it.

Top module: `zt_sram_core`

## Requirements
- R1: A command is captured at a rising edge where `cke_n` is low. The part counts as selected when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A selected command with `we_n`=1 is a read, and a selected command with `we_n`=0 is a write.
- R2: A read drives `data_out` with the addressed word and raises `data_oe` in the clock cycle that follows its command edge, with no further register on the path.
- R3: Write data is sampled from `data_in` at the first enabled edge after the write command. Only lanes whose `bw_n` bit is 0 are updated, where lane i occupies bits 9i+8 down to 9i.
- R4: During the data cycle of a write, `data_oe` is 0.
- R5: Reads and writes may be issued on consecutive enabled edges in any order, with no idle cycle, and each still returns or stores the correct data.
- R6: A read of the address of the most recent write returns the newly written lanes, merged with the older contents of the unwritten lanes. This holds even when the read command is issued on the very edge that delivers the write data.
- R7: An edge with `cke_n`=1 is ignored. Commands, pending data, array contents and `data_out` all hold, and a write waiting for its data takes it at the next enabled edge.
- R8: A command edge with any chip select inactive performs no operation. `data_oe` is 0 in the following cycle and no memory word changes, even with `we_n`=0.
- R9: `oe_n`=1 forces `data_oe` to 0 immediately, without waiting for a clock edge. It has no effect on reads or writes.
- R10: After reset, no command is in progress, `data_oe` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the block |
| ce1_n | input | 1 | Active-low chip select |
| ce2 | input | 1 | Active-high chip select |
| ce3_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write command |
| bw_n | input | LANES (4) | Active-low lane write strobes, one per 9-bit lane |
| addr | input | ADDR_W (8) | Word address |
| data_in | input | LANES*LANE_W (36) | Write data, sampled one enabled edge after the write command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| data_out | output | LANES*LANE_W (36) | Read word (zero outside a read cycle) |
| data_oe | output | 1 | Bus drive enable for the data pads |

## Verification
The embedded properties assume that `rst_n` is low from time zero. They also assume that every synchronous input is stable around each rising edge, so the value sampled at one edge describes the command whose effects appear before the next edge. The stimulus meets these assumptions by changing all inputs only on the falling edge. The one exception is `oe_n`, which is deliberately toggled mid-cycle to exercise its asynchronous path. The array is also filled completely before any read, because the properties and the reference model say nothing about never-written words.

// File: rtl/zt_pkg.sv
`timescale 1ns/1ps
package zt_pkg;

  // phase of the cycle following a captured command
  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } zt_phase_e;

  // three-way chip select decode
  function automatic logic zt_selected(input logic c1_n, input logic c2, input logic c3_n);
    return (!c1_n) && c2 && (!c3_n);
  endfunction

endpackage

// File: rtl/zt_cmd_reg.sv
`timescale 1ns/1ps
module zt_cmd_reg
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  output zt_phase_e         phase_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  be_q
);

  zt_phase_e phase_d;

  always_comb begin
    if (zt_selected(ce1_n, ce2, ce3_n)) phase_d = we_n ? PH_RD : PH_WR;
    else                                phase_d = PH_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_NONE;
      addr_q  <= '0;
      be_q    <= '0;
    end else if (!cke_n) begin
      phase_q <= phase_d;
      addr_q  <= addr;
      be_q    <= ~bw_n;
    end
  end

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(phase_q) && $stable(addr_q) && $stable(be_q)));

endmodule

// File: rtl/zt_wr_pend.sv
`timescale 1ns/1ps
module zt_wr_pend
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  zt_phase_e         phase,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  cmd_be,
  input  logic [DATA_W-1:0] data_in,
  output logic              pend_vld,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [LANES-1:0]  pend_be,
  output logic [DATA_W-1:0] pend_data,
  output logic              commit_en
);

  logic take;

  // new write data arrives on an enabled edge during a write data cycle
  assign take      = (!cke_n) && (phase == PH_WR);
  // the older pending word is retired into the array at that same edge
  assign commit_en = take && pend_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_be   <= '0;
      pend_data <= '0;
    end else if (take) begin
      pend_vld  <= 1'b1;
      pend_addr <= cmd_addr;
      pend_be   <= cmd_be;
      pend_data <= data_in;
    end
  end

  // R3
  pend_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_vld) |-> $past((phase == PH_WR) && !cke_n));

endmodule

// File: rtl/zt_array.sv
`timescale 1ns/1ps
module zt_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/zt_rd_path.sv
`timescale 1ns/1ps
module zt_rd_path
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  zt_phase_e         phase,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              pend_vld,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [LANES-1:0]  pend_be,
  input  logic [DATA_W-1:0] pend_data,
  input  logic              oe_n,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);

  logic              hit;
  logic [DATA_W-1:0] merged;

  assign hit = pend_vld && (pend_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (hit && pend_be[g]) ?
      pend_data[g*LANE_W +: LANE_W] : arr_data[g*LANE_W +: LANE_W];
  end

  assign data_out = (phase == PH_RD) ? merged : '0;
  assign data_oe  = (phase == PH_RD) && !oe_n;

endmodule

// File: rtl/zt_sram_core.sv
`timescale 1ns/1ps
module zt_sram_core
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              oe_n,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);

  zt_phase_e         phase;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_be;
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_be;
  logic [DATA_W-1:0] pend_data;
  logic              commit_en;
  logic [DATA_W-1:0] arr_data;

  zt_cmd_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke_n   (cke_n),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .ce3_n   (ce3_n),
    .we_n    (we_n),
    .bw_n    (bw_n),
    .addr    (addr),
    .phase_q (phase),
    .addr_q  (cmd_addr),
    .be_q    (cmd_be)
  );

  zt_wr_pend #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .phase     (phase),
    .cmd_addr  (cmd_addr),
    .cmd_be    (cmd_be),
    .data_in   (data_in),
    .pend_vld  (pend_vld),
    .pend_addr (pend_addr),
    .pend_be   (pend_be),
    .pend_data (pend_data),
    .commit_en (commit_en)
  );

  zt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .wr_en   (commit_en),
    .wr_addr (pend_addr),
    .wr_be   (pend_be),
    .wr_data (pend_data),
    .rd_addr (cmd_addr),
    .rd_data (arr_data)
  );

  zt_rd_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
    .phase     (phase),
    .rd_addr   (cmd_addr),
    .arr_data  (arr_data),
    .pend_vld  (pend_vld),
    .pend_addr (pend_addr),
    .pend_be   (pend_be),
    .pend_data (pend_data),
    .oe_n      (oe_n),
    .data_out  (data_out),
    .data_oe   (data_oe)
  );

  // port-level decode used only by the checks below
  logic sel_in;
  assign sel_in = (!ce1_n) && ce2 && (!ce3_n);

  // R4
  wr_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cke_n && sel_in && !we_n) |-> !data_oe);

  // R8
  desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cke_n && !sel_in) |-> !data_oe);

  // R7
  stall_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(data_out));

  // R9
  always_comb begin
    if (oe_n) begin
      oe_gate_chk: assert (!data_oe);
    end
  end

endmodule

// File: tb/zt_sram_core_tb.sv
`timescale 1ns/1ps
module zt_sram_core_tb;

  localparam int AW    = 8;
  localparam int LN    = 4;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk    = 1'b0;
  logic          rst_n  = 1'b0;
  logic          cke_n  = 1'b1;
  logic          ce1_n  = 1'b1;
  logic          ce2    = 1'b0;
  logic          ce3_n  = 1'b1;
  logic          we_n   = 1'b1;
  logic [LN-1:0] bw_n   = '1;
  logic [AW-1:0] addr   = '0;
  logic [DW-1:0] data_in = '0;
  logic          oe_n   = 1'b0;
  logic [DW-1:0] data_out;
  logic          data_oe;

  always #2.5 clk = ~clk;

  zt_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .we_n(we_n), .bw_n(bw_n), .addr(addr), .data_in(data_in),
    .oe_n(oe_n), .data_out(data_out), .data_oe(data_oe)
  );

  // behavioural reference
  logic [DW-1:0] ref_mem [DEPTH];
  bit            part_w  [DEPTH];
  int            m_ph    = 0;   // 0 idle, 1 read, 2 write
  int            prev_ph = 0;
  logic [AW-1:0] m_addr  = '0;
  logic [LN-1:0] m_be    = '0;
  int            last_wr = -1;

  int vecs  = 0;
  int fails = 0;
  bit done  = 0;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit ck_n, bit c1n, bit c2, bit c3n, bit wn,
                      logic [LN-1:0] bwn, logic [AW-1:0] a, bit oen);
    logic [63:0] r;
    string       t;
    @(negedge clk);
    r = {$urandom(), $urandom()};
    cke_n = ck_n; ce1_n = c1n; ce2 = c2; ce3_n = c3n; we_n = wn;
    bw_n = bwn; addr = a; oe_n = oen; data_in = r[DW-1:0];
    @(posedge clk);
    if (!ck_n) begin
      if (m_ph == 2) begin
        for (int i = 0; i < LN; i++)
          if (m_be[i]) ref_mem[m_addr][i*LW +: LW] = data_in[i*LW +: LW];
        part_w[m_addr] = (m_be != '1);
        last_wr = int'(m_addr);
      end
      prev_ph = m_ph;
      if (!c1n && c2 && !c3n) m_ph = wn ? 2 - 1 : 2;
      else                    m_ph = 0;
      m_addr = a;
      m_be   = ~bwn;
    end
    #2;
    if (ck_n)         t = "R7";
    else if (oen)     t = "R9";
    else if (m_ph==0) t = "R8";
    else if (m_ph==2) t = "R4";
    else              t = "R1";
    chk({t, " drive enable"}, DW'(data_oe), DW'(m_ph == 1 && !oen));
    if (m_ph == 1) begin
      if (ck_n)                         t = "R7";
      else if (int'(m_addr) == last_wr) t = "R6";
      else if (part_w[m_addr])          t = "R3";
      else if (prev_ph == 2)            t = "R5";
      else                              t = "R2";
      chk({t, " read word"}, data_out, ref_mem[m_addr]);
    end
  endtask

  task automatic rd(logic [AW-1:0] a);
    step(0, 0, 1, 0, 1, '1, a, 0);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [LN-1:0] bwn);
    step(0, 0, 1, 0, 0, bwn, a, 0);
  endtask

  task automatic idle();
    step(0, 1, 1, 0, 1, '1, '0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10 drive enable after reset", DW'(data_oe), '0);
    chk("R10 read word after reset", data_out, '0);
    idle();

    // fill every word back to back (R5 write stream)
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), '0);
    idle();
    for (int a = 0; a < 16; a++) rd(AW'(a));

    // R6 read on the data edge, partial lanes (R3)
    wr(8'h21, 4'b1010);
    rd(8'h21);
    wr(8'h21, 4'b0101);
    wr(8'h22, 4'b0110);
    rd(8'h21);
    rd(8'h22);
    idle();
    rd(8'h21);

    // R8 each inactive select with a write attempt, then read back
    step(0, 1, 1, 0, 0, '0, 8'h30, 0); rd(8'h30);
    step(0, 0, 0, 0, 0, '0, 8'h31, 0); rd(8'h31);
    step(0, 0, 1, 1, 0, '0, 8'h32, 0); rd(8'h32);

    // R7 stall during write data phase and during a read
    wr(8'h40, 4'b0000);
    step(1, 0, 1, 0, 1, '1, 8'h41, 0);
    step(1, 0, 1, 0, 1, '1, 8'h42, 0);
    rd(8'h40);
    step(1, 0, 1, 0, 0, '0, 8'h43, 0);
    rd(8'h40);

    // R9 asynchronous output enable
    rd(8'h05);
    oe_n = 1'b1; #0.2;
    chk("R9 async float", DW'(data_oe), '0);
    oe_n = 1'b0; #0.1;
    chk("R9 async drive", DW'(data_oe), DW'(1));
    step(0, 0, 1, 0, 1, '1, 8'h06, 1);

    // R5 alternating reads and writes over a few addresses
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a = AW'($urandom_range(0, 7));
      if (i % 2 == 0) wr(a, LN'($urandom()));
      else            rd(a);
    end

    // mixed traffic with stalls, deselects and output-enable changes
    for (int i = 0; i < 1500; i++) begin
      int k = $urandom_range(0, 9);
      bit ck = ($urandom_range(0, 4) == 0);
      bit oe = ($urandom_range(0, 5) == 0);
      logic [AW-1:0] a = AW'($urandom_range(0, 15));
      if (k < 4)      step(ck, 0, 1, 0, 1, '1, a, oe);
      else if (k < 8) step(ck, 0, 1, 0, 0, LN'($urandom()), a, oe);
      else            step(ck, bit'($urandom_range(0, 1)), 0, 0, 0, '0, a, oe);
    end

    idle();
    for (int a = 0; a < 16; a++) rd(AW'(a));
    finish_run();
  end

endmodule